// File: doc/BRIEF.md
# Prescaled Gated PWM / Capture Timer

A general-purpose timer/counter for a peripheral subsystem. A counter is advanced by ticks from a power-of-two prescaler fed by the system clock. An optional gate input can freeze it. Software picks one of three working modes through a small register port. Timer mode restarts the count after it meets the FALL compare value, which gives a periodic event. PWM mode uses the same compare pair to drive a square wave whose duty is set by the RISE and FALL values. Capture mode stores the count seen at the first rising and the first falling edge of an external signal.

Match and capture events set sticky status bits, which software clears by writing 1. The interrupt line is the registered OR of the status bits whose enables are set. Any write to the control register restarts the counter and the prescaler, so a new setting always begins from a known phase.

Top module: `pwm_capture_timer`

## Requirements
- R1: After reset every register reads 0, the count is 0, and `pwm_out` and `irq` are low.
- R2: With prescale field N (control bits [7:3]) the counter advances once every 2^N clocks. N=0 advances it every clock.
- R3: When the gate enable (control bit 2) is 1, the counter holds while the synchronized `gate_in` is high and counts while it is low. When the gate enable is 0, `gate_in` has no effect.
- R4: In timer mode (mode field bits [1:0] = 1) and in PWM mode (mode = 2), the counter returns to 0 on the advance after it equals FALL. The period is therefore (FALL+1)·2^N clocks.
- R5: In timer and PWM modes, an advance while the count equals RISE sets status bit 0, and an advance while the count equals FALL sets status bit 1.
- R6: In PWM mode `pwm_out` goes high at the RISE match and low at the FALL match. It is high for (FALL−RISE)·2^N clocks in each period. Outside PWM mode it stays low.
- R7: In capture mode (mode = 3), `cap_in` passes through a two-flop synchronizer. The first rising edge after arming stores the count in RISE and sets status bit 0. The first falling edge stores the count in FALL and sets status bit 1. Later edges are ignored until a control write in capture mode arms the block again.
- R8: Writing the status register (address 3) clears each status bit whose written bit is 1 and leaves the others unchanged.
- R9: `irq` is the registered OR of (status bit 0 AND rise enable, control bit 8) and (status bit 1 AND fall enable, control bit 9).
- R10: A write to the control register resets the counter and the prescaler to 0 and drives `pwm_out` low.
- R11: Register map: 0 control, 1 RISE, 2 FALL, 3 status, 4 count (read only). `rd_data` returns the register at `rd_addr` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Registered read data, one clock after `rd_addr` |
| gate_in | input | 1 | Asynchronous gate; freezes counting while high if enabled |
| cap_in | input | 1 | Asynchronous capture input |
| pwm_out | output | 1 | Registered PWM output |
| irq | output | 1 | Registered interrupt request |

## Verification
Most internal faults show up at the ports within one timer period. A wrong prescaler phase changes the count read back after a fixed number of clocks. A wrong wrap or compare point changes the measured interval between interrupts, or the number of high cycles of `pwm_out` counted over a whole number of periods. A synchronizer with the wrong depth or a bad capture arm shows up in the very next read of RISE or FALL. A delay error moves the captured value, and a capture that should have been ignored overwrites it. A status or enable fault shows on `irq` two clocks after the write that causes it.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_TIMER   = 2'd1,
    MODE_PWM     = 2'd2,
    MODE_CAPTURE = 2'd3
  } tmr_mode_e;

  localparam int unsigned ADDR_CTRL   = 0;
  localparam int unsigned ADDR_RISE   = 1;
  localparam int unsigned ADDR_FALL   = 2;
  localparam int unsigned ADDR_STATUS = 3;
  localparam int unsigned ADDR_COUNT  = 4;
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
  parameter int PRE_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [PRE_W-1:0] shift,
  output logic             tick
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  // all-ones mask of width shift; shift = 0 gives an empty mask, so every clock ticks
  assign mask = (DIV_W'(1) << shift) - DIV_W'(1);
  assign tick = ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr) div_q <= '0;
    else            div_q <= div_q + DIV_W'(1);
  end

  // R2: a divided tick never repeats on the next clock
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && (shift != '0) && !clr) |=> !tick);
endmodule

// File: rtl/ptmr_sync.sv
module ptmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= d;
  end

  genvar i;
  generate
    for (i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign q    = chain[STAGES-1];
  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic             wrap_en,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)                  cnt <= '0;
    else if (adv) begin
      if (wrap_en && (cnt == limit)) cnt <= '0;
      else                           cnt <= cnt + CNT_W'(1);
    end
  end

  // R3: with no advance the count holds
  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!clr && !adv) |=> $stable(cnt));
  // R10: a restart leaves the count at zero
  assert_restart_zero_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
  // R4: an advance at the limit wraps to zero
  assert_wrap_at_limit_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && wrap_en && !clr && (cnt == limit)) |=> (cnt == '0));
endmodule

// File: rtl/pwm_capture_timer.sv
module pwm_capture_timer
  import ptmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 5,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              gate_in,
  input  logic              cap_in,
  output logic              pwm_out,
  output logic              irq
);
  localparam int GATE_BIT = 2;
  localparam int PRE_LSB  = 3;
  localparam int IER_BIT  = PRE_LSB + PRE_W;
  localparam int IEF_BIT  = IER_BIT + 1;

  tmr_mode_e        mode_q;
  logic             gate_en_q;
  logic [PRE_W-1:0] pre_q;
  logic             ie_rise_q, ie_fall_q;
  logic [CNT_W-1:0] rise_q, fall_q;
  logic             st_rise_q, st_fall_q;
  logic             arm_rise_q, arm_fall_q;
  logic             pwm_q, irq_q;
  logic [CNT_W-1:0] rd_q;

  logic             ctrl_wr, rise_wr, fall_wr, stat_wr;
  logic             tick, gate_s, cap_s, cap_rise, cap_fall;
  logic             adv, cmp_mode, rise_hit, fall_hit, cap_r_ev, cap_f_ev;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ctrl_view;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
  assign rise_wr = wr_en && (wr_addr == ADDR_W'(ADDR_RISE));
  assign fall_wr = wr_en && (wr_addr == ADDR_W'(ADDR_FALL));
  assign stat_wr = wr_en && (wr_addr == ADDR_W'(ADDR_STATUS));

  ptmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .clr(ctrl_wr), .shift(pre_q), .tick(tick)
  );

  ptmr_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk), .rst(rst), .d(gate_in), .q(gate_s), .rise(), .fall()
  );

  ptmr_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk(clk), .rst(rst), .d(cap_in), .q(cap_s), .rise(cap_rise), .fall(cap_fall)
  );

  assign cmp_mode = (mode_q == MODE_TIMER) || (mode_q == MODE_PWM);
  assign adv      = tick && (mode_q != MODE_OFF) && !(gate_en_q && gate_s);
  assign rise_hit = adv && cmp_mode && !ctrl_wr && (cnt == rise_q);
  assign fall_hit = adv && cmp_mode && !ctrl_wr && (cnt == fall_q);
  assign cap_r_ev = (mode_q == MODE_CAPTURE) && arm_rise_q && cap_rise && !ctrl_wr;
  assign cap_f_ev = (mode_q == MODE_CAPTURE) && arm_fall_q && cap_fall && !ctrl_wr;

  ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(ctrl_wr), .adv(adv),
    .wrap_en(cmp_mode), .limit(fall_q), .cnt(cnt)
  );

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_OFF;
      gate_en_q <= 1'b0;
      pre_q     <= '0;
      ie_rise_q <= 1'b0;
      ie_fall_q <= 1'b0;
    end else if (ctrl_wr) begin
      mode_q    <= tmr_mode_e'(wr_data[1:0]);
      gate_en_q <= wr_data[GATE_BIT];
      pre_q     <= wr_data[PRE_LSB +: PRE_W];
      ie_rise_q <= wr_data[IER_BIT];
      ie_fall_q <= wr_data[IEF_BIT];
    end
  end

  // compare / capture registers; a capture wins over a software write
  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      if (cap_r_ev)     rise_q <= cnt;
      else if (rise_wr) rise_q <= wr_data;
      if (cap_f_ev)     fall_q <= cnt;
      else if (fall_wr) fall_q <= wr_data;
    end
  end

  // capture arming: set by a control write into capture mode, spent by the first edge
  always_ff @(posedge clk) begin
    if (rst) begin
      arm_rise_q <= 1'b0;
      arm_fall_q <= 1'b0;
    end else if (ctrl_wr) begin
      arm_rise_q <= (wr_data[1:0] == MODE_CAPTURE);
      arm_fall_q <= (wr_data[1:0] == MODE_CAPTURE);
    end else begin
      if (cap_r_ev) arm_rise_q <= 1'b0;
      if (cap_f_ev) arm_fall_q <= 1'b0;
    end
  end

  // sticky status, write 1 to clear; a new event wins over a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      st_rise_q <= 1'b0;
      st_fall_q <= 1'b0;
    end else begin
      if (rise_hit || cap_r_ev)     st_rise_q <= 1'b1;
      else if (stat_wr && wr_data[0]) st_rise_q <= 1'b0;
      if (fall_hit || cap_f_ev)     st_fall_q <= 1'b1;
      else if (stat_wr && wr_data[1]) st_fall_q <= 1'b0;
    end
  end

  // PWM output and interrupt
  always_ff @(posedge clk) begin
    if (rst || ctrl_wr)                     pwm_q <= 1'b0;
    else if (mode_q == MODE_PWM && fall_hit) pwm_q <= 1'b0;
    else if (mode_q == MODE_PWM && rise_hit) pwm_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (st_rise_q && ie_rise_q) || (st_fall_q && ie_fall_q);
  end

  // read port
  always_comb begin
    ctrl_view                     = '0;
    ctrl_view[1:0]                = mode_q;
    ctrl_view[GATE_BIT]           = gate_en_q;
    ctrl_view[PRE_LSB +: PRE_W]   = pre_q;
    ctrl_view[IER_BIT]            = ie_rise_q;
    ctrl_view[IEF_BIT]            = ie_fall_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      case (rd_addr)
        ADDR_W'(ADDR_CTRL):   rd_q <= ctrl_view;
        ADDR_W'(ADDR_RISE):   rd_q <= rise_q;
        ADDR_W'(ADDR_FALL):   rd_q <= fall_q;
        ADDR_W'(ADDR_STATUS): rd_q <= {{(CNT_W-2){1'b0}}, st_fall_q, st_rise_q};
        ADDR_W'(ADDR_COUNT):  rd_q <= cnt;
        default:              rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;
  assign pwm_out = pwm_q;
  assign irq     = irq_q;

  // R6: the output stays low whenever PWM mode is not selected
  assert_pwm_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_PWM) |-> !pwm_out);
  // R7: once spent, the rise capture cannot change without a software action
  assert_capture_once_R7: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == MODE_CAPTURE) && !arm_rise_q && !ctrl_wr && !rise_wr) |=> $stable(rise_q));
endmodule

// File: tb/pwm_capture_timer_bench.sv
module pwm_capture_timer_bench;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 3;

  logic              clk = 1'b0;
  logic              rst;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [CNT_W-1:0]  wr_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [CNT_W-1:0]  rd_data;
  logic              gate_in, cap_in, pwm_out, irq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic req = 1'b0, req_d = 1'b0;

  typedef struct {
    logic [CNT_W-1:0] exp;
    string            tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) begin
    cyc   <= cyc + 1;
    req_d <= req;
  end

  pwm_capture_timer u_pwm_capture_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .gate_in(gate_in), .cap_in(cap_in),
    .pwm_out(pwm_out), .irq(irq)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when a read result is due
  always @(negedge clk) begin
    if (req_d) begin
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read result with no expectation, actual=%0d expected=none", rd_data);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(int'(rd_data), int'(it.exp), it.tag);
      end
    end
  end

  // all tasks are entered and left on a falling edge
  task automatic wr(input int addr, input int data);
    wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = CNT_W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int addr, input int exp, input string tag);
    sb_item_t it;
    it.exp = CNT_W'(exp); it.tag = tag;
    sb_q.push_back(it);
    rd_addr = ADDR_W'(addr); req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic high_count(input int n, input int exp, input string tag);
    int hi = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
    check(hi, exp, tag);
  endtask

  function automatic int cw(input int mode, input int gate, input int pre,
                            input int ier, input int ief);
    return mode | (gate << 2) | (pre << 3) | (ier << 8) | (ief << 9);
  endfunction

  task automatic finish_run();
    waitc(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t0, t1;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    gate_in = 1'b0; cap_in = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(0, 0, "R1 ctrl after reset");
    rd(1, 0, "R1 rise after reset");
    rd(2, 0, "R1 fall after reset");
    rd(3, 0, "R1 status after reset");
    rd(4, 0, "R1 count after reset");
    check(pwm_out, 0, "R1 pwm_out after reset");
    check(irq, 0, "R1 irq after reset");

    // R11 map and readback
    wr(1, 16'h1234); wr(2, 16'h0abc);
    rd(1, 16'h1234, "R11 rise readback");
    rd(2, 16'h0abc, "R11 fall readback");
    wr(0, cw(0, 1, 7, 1, 0));
    rd(0, cw(0, 1, 7, 1, 0), "R11 ctrl readback");

    // R10 restart on control write
    wr(2, 1000);
    wr(0, cw(1, 0, 0, 0, 0));
    waitc(50);
    wr(0, cw(1, 0, 0, 0, 0));
    rd(4, 0, "R10 count restarted");

    // R2 prescaler
    wr(0, cw(1, 0, 3, 0, 0)); waitc(40); rd(4, 5, "R2 prescale 3");
    wr(0, cw(1, 0, 0, 0, 0)); waitc(13); rd(4, 13, "R2 prescale 0");
    wr(0, cw(1, 0, 2, 0, 0)); waitc(21); rd(4, 5, "R2 prescale 2");

    // R3 gate
    gate_in = 1'b1; waitc(4);
    wr(0, cw(1, 1, 0, 0, 0)); waitc(10);
    rd(4, 0, "R3 frozen while gate high");
    gate_in = 1'b0; waitc(20); gate_in = 1'b1; waitc(10);
    rd(4, 20, "R3 counts only while gate low");
    wr(0, cw(1, 0, 0, 0, 0)); waitc(9);
    rd(4, 9, "R3 gate ignored when disabled");
    gate_in = 1'b0;

    // R4 / R5 / R9 timer period via interrupt spacing
    wr(3, 3); wr(1, 0); wr(2, 5);
    wr(0, cw(1, 0, 2, 0, 1));
    while (!irq) @(negedge clk);
    t0 = cyc;
    wr(3, 2);
    while (irq) @(negedge clk);
    while (!irq) @(negedge clk);
    t1 = cyc;
    check(t1 - t0, 24, "R4 timer period (F+1)*2^N");

    // R5 / R8 / R9 with the counter stopped
    wr(0, cw(0, 0, 0, 1, 0));
    rd(3, 3, "R5 rise and fall flags set");
    wr(3, 2); waitc(2);
    rd(3, 1, "R8 clear of bit 1 keeps bit 0");
    check(irq, 1, "R9 irq from enabled rise flag");
    wr(0, cw(0, 0, 0, 0, 0)); waitc(2);
    check(irq, 0, "R9 irq masked when disabled");
    wr(3, 1);
    rd(3, 0, "R8 clear of bit 0");

    // R6 PWM duty
    wr(1, 2); wr(2, 5);
    wr(0, cw(2, 0, 0, 0, 0)); waitc(30);
    high_count(60, 30, "R6 duty prescale 0");
    wr(0, cw(2, 0, 1, 0, 0)); waitc(40);
    high_count(48, 24, "R6 duty prescale 1");
    wr(0, cw(1, 0, 0, 0, 0)); waitc(5);
    high_count(20, 0, "R6 low outside PWM mode");
    wr(0, cw(0, 0, 0, 0, 0)); wr(3, 3);

    // R7 capture
    wr(0, cw(3, 0, 0, 0, 0));
    waitc(5); cap_in = 1'b1; waitc(7); cap_in = 1'b0; waitc(10);
    rd(1, 7, "R7 rise capture");
    rd(2, 14, "R7 fall capture");
    rd(3, 3, "R7 capture flags");
    cap_in = 1'b1; waitc(5); cap_in = 1'b0; waitc(10);
    rd(1, 7, "R7 later rising edge ignored");
    rd(2, 14, "R7 later falling edge ignored");
    wr(0, cw(3, 0, 0, 0, 0));
    waitc(2); cap_in = 1'b1; waitc(4); cap_in = 1'b0; waitc(8);
    rd(1, 4, "R7 rearmed rise capture");
    rd(2, 8, "R7 rearmed fall capture");

    finish_run();
  end
endmodule